// File: doc/BRIEF.md
# Serial Flash Hold Controller

This block implements the pause logic on the serial port of a flash-style SPI slave. It runs on a fast internal clock and samples three pins: the active-low select, the serial clock and an active-low pause request. When a pause is accepted it freezes the downstream shift and command engine. It does this by gating off the serial clock and data-in that the engine sees, and by releasing the data output driver. The engine's contents are kept, so the transfer continues from the same bit once the pause ends.

A pause starts or ends only while the serial clock is low. A request edge that arrives during a high clock phase waits for the next low phase. If the select pin is released while a pause is active, the block sends a one-cycle reset pulse to the engine. It then refuses to talk until the pause pin is released and a fresh select begins. Any program, erase or status-write job that is already running is untouched, because only the serial path is gated.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, hold_active_o=0, if_reset_o=0, clk_gate_en_o=1 and do_oe_o=0.
- R2: A falling pause pin while select is high (deselected) starts no pause, and no pause appears after a later select.
- R3: With select low and serial clock low, a falling pause pin sets hold_active_o within SYNC_STAGES+2 clock cycles.
- R4: If the pause pin falls while the serial clock is high, hold_active_o stays 0 until the serial clock goes low, and then becomes 1.
- R5: A pause pin that goes low and returns high within one high phase of the serial clock starts no pause.
- R6: A rising pause pin ends the pause if the serial clock is low. Otherwise the pause ends only after the serial clock next goes low.
- R7: do_oe_o equals drive_req_i only while selected and not paused or locked out; it is 0 during a pause and while deselected.
- R8: During a pause clk_gate_en_o=0, sclk_int_o=0 and sdi_int_o holds its value. Outside a pause sclk_int_o follows the synchronized serial clock.
- R9: Select going high during a pause clears hold_active_o and gives exactly one if_reset_o pulse of one cycle.
- R10: After an R9 reset, select low with the pause pin still low keeps clk_gate_en_o=0 and do_oe_o=0. Only a release of the pause pin with select high, followed by a new select, restores normal operation.
- R11: Select going high while an entry is still waiting for a low clock phase gives no if_reset_o pulse and no pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oversampling clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Select pin, active low (asynchronous) |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| hold_n_i | input | 1 | Pause request pin, active low (asynchronous) |
| sdi_i | input | 1 | Serial data-in pin (asynchronous) |
| drive_req_i | input | 1 | Engine wants to drive the data output |
| hold_active_o | output | 1 | Pause in effect |
| do_oe_o | output | 1 | Data output driver enable |
| clk_gate_en_o | output | 1 | Serial path enabled toward the engine |
| sclk_int_o | output | 1 | Gated, synchronized serial clock for the engine |
| sdi_int_o | output | 1 | Gated, synchronized data-in for the engine |
| if_reset_o | output | 1 | One-cycle reset pulse for the engine |

## Verification
A wrong internal state shows at the ports within SYNC_STAGES+2 cycles of a pin change. It appears as hold_active_o and clk_gate_en_o disagreeing with the pin history, or as do_oe_o driving during a pause. An entry or exit that is not qualified by the clock level shows up as a pause that begins or ends while the serial clock is still high. A missed lockout shows up as clk_gate_en_o returning after a select while the pause pin is still low. A duplicated or missing reset shows up as a wrong count of if_reset_o pulses.

// File: rtl/spi_hold_pkg.sv
// Shared definitions for the serial pause controller.
// Assumes every pin is sampled as one bit of a packed pin vector.
package spi_hold_pkg;
    typedef enum logic [1:0] {
        HC_IDLE    = 2'd0,
        HC_ACTIVE  = 2'd1,
        HC_HOLD    = 2'd2,
        HC_LOCKOUT = 2'd3
    } hc_state_e;

    localparam int PIN_W   = 4;
    localparam int IDX_CSN = 0;
    localparam int IDX_CLK = 1;
    localparam int IDX_HLD = 2;
    localparam int IDX_SDI = 3;
    // Idle pin levels: deselected, clock low, pause released, data low.
    localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0101;
endpackage

// File: rtl/spi_hold_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes the pins are quasi-static compared with clk_i. Each bit is treated on its own.
module spi_hold_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First capture of the raw pins.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stage_q[g] <= RST_VAL;
                else         stage_q[g] <= d_i;
            end
        end else begin : g_next
            // Later stages take the previous stage.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stage_q[g] <= RST_VAL;
                else         stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
// Rise and fall detector on a synchronized level.
// Assumes the input is already in the clk_i domain.
module spi_hold_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // Keep the previous sample for comparison.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= RST_VAL;
        else         prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_hold_fsm.sv
// Pause state machine. It qualifies entry and exit by the serial clock level,
// keeps pending flags for edges seen during a high clock phase, and enforces
// the lockout that follows a deselect during a pause.
// Assumes all inputs are synchronized to clk_i.
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      cs_n_s,
    input  logic      sclk_s,
    input  logic      hold_n_s,
    input  logic      hold_fall,
    input  logic      hold_rise,
    output hc_state_e state_o,
    output logic      if_reset_o
);
    hc_state_e state_q, state_d;
    logic      pend_entry_q, pend_entry_d;
    logic      pend_exit_q, pend_exit_d;
    logic      rst_pulse_d;

    // Next-state and pending-flag decisions.
    always_comb begin
        state_d      = state_q;
        pend_entry_d = pend_entry_q;
        pend_exit_d  = pend_exit_q;
        rst_pulse_d  = 1'b0;
        case (state_q)
            HC_IDLE: begin
                pend_entry_d = 1'b0;
                pend_exit_d  = 1'b0;
                if (!cs_n_s) state_d = HC_ACTIVE;
            end
            HC_ACTIVE: begin
                if (cs_n_s) begin
                    state_d      = HC_IDLE;
                    pend_entry_d = 1'b0;
                end else if (pend_entry_q) begin
                    if (hold_n_s) begin
                        pend_entry_d = 1'b0;
                    end else if (!sclk_s) begin
                        state_d      = HC_HOLD;
                        pend_entry_d = 1'b0;
                    end
                end else if (hold_fall) begin
                    if (!sclk_s) state_d      = HC_HOLD;
                    else         pend_entry_d = 1'b1;
                end
            end
            HC_HOLD: begin
                if (cs_n_s) begin
                    state_d     = HC_LOCKOUT;
                    pend_exit_d = 1'b0;
                    rst_pulse_d = 1'b1;
                end else if (pend_exit_q) begin
                    if (!hold_n_s) begin
                        pend_exit_d = 1'b0;
                    end else if (!sclk_s) begin
                        state_d     = HC_ACTIVE;
                        pend_exit_d = 1'b0;
                    end
                end else if (hold_rise) begin
                    if (!sclk_s) state_d     = HC_ACTIVE;
                    else         pend_exit_d = 1'b1;
                end
            end
            HC_LOCKOUT: begin
                if (cs_n_s && hold_n_s) state_d = HC_IDLE;
            end
            default: state_d = HC_IDLE;
        endcase
    end

    // State, flag and reset-pulse registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q      <= HC_IDLE;
            pend_entry_q <= 1'b0;
            pend_exit_q  <= 1'b0;
            if_reset_o   <= 1'b0;
        end else begin
            state_q      <= state_d;
            pend_entry_q <= pend_entry_d;
            pend_exit_q  <= pend_exit_d;
            if_reset_o   <= rst_pulse_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/spi_hold_gate.sv
// Output gating toward the shift engine: the driver enable, the clock gate,
// and a data-in value that freezes while the path is gated.
// Assumes the state comes from spi_hold_fsm in the same clock domain.
module spi_hold_gate
    import spi_hold_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  hc_state_e state_i,
    input  logic      sclk_s,
    input  logic      sdi_s,
    input  logic      drive_req_i,
    output logic      clk_gate_en_o,
    output logic      do_oe_o,
    output logic      sclk_int_o,
    output logic      sdi_int_o
);
    logic sdi_keep_q;

    assign clk_gate_en_o = (state_i == HC_IDLE) || (state_i == HC_ACTIVE);
    assign do_oe_o       = drive_req_i && (state_i == HC_ACTIVE);
    assign sclk_int_o    = sclk_s & clk_gate_en_o;
    assign sdi_int_o     = clk_gate_en_o ? sdi_s : sdi_keep_q;

    // Remember the last data-in value seen while the path was open.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)            sdi_keep_q <= 1'b0;
        else if (clk_gate_en_o) sdi_keep_q <= sdi_s;
    end
endmodule

// File: rtl/spi_hold_ctrl.sv
// Top of the serial pause controller: synchronizers, edge detection,
// the pause state machine and output gating.
// Assumes clk_i is several times faster than the serial clock.
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic hold_n_i,
    input  logic sdi_i,
    input  logic drive_req_i,
    output logic hold_active_o,
    output logic do_oe_o,
    output logic clk_gate_en_o,
    output logic sclk_int_o,
    output logic sdi_int_o,
    output logic if_reset_o
);
    logic [PIN_W-1:0] pins_raw, pins_s;
    logic             cs_n_s, sclk_s, hold_n_s, sdi_s;
    logic             hold_rise, hold_fall;
    hc_state_e        state;

    always_comb begin
        pins_raw          = '0;
        pins_raw[IDX_CSN] = cs_n_i;
        pins_raw[IDX_CLK] = sclk_i;
        pins_raw[IDX_HLD] = hold_n_i;
        pins_raw[IDX_SDI] = sdi_i;
    end

    spi_hold_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign cs_n_s   = pins_s[IDX_CSN];
    assign sclk_s   = pins_s[IDX_CLK];
    assign hold_n_s = pins_s[IDX_HLD];
    assign sdi_s    = pins_s[IDX_SDI];

    spi_hold_edge #(.RST_VAL(1'b1)) u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (hold_n_s),
        .rise_o(hold_rise),
        .fall_o(hold_fall)
    );

    spi_hold_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .hold_n_s  (hold_n_s),
        .hold_fall (hold_fall),
        .hold_rise (hold_rise),
        .state_o   (state),
        .if_reset_o(if_reset_o)
    );

    spi_hold_gate u_gate (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .state_i      (state),
        .sclk_s       (sclk_s),
        .sdi_s        (sdi_s),
        .drive_req_i  (drive_req_i),
        .clk_gate_en_o(clk_gate_en_o),
        .do_oe_o      (do_oe_o),
        .sclk_int_o   (sclk_int_o),
        .sdi_int_o    (sdi_int_o)
    );

    assign hold_active_o = (state == HC_HOLD);
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
// Property checker for spi_hold_ctrl, attached by bind.
// Assumes sclk_s is the synchronized serial clock inside the top.
module spi_hold_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sclk_s,
    input logic hold_active_o,
    input logic do_oe_o,
    input logic clk_gate_en_o,
    input logic sclk_int_o,
    input logic sdi_int_o,
    input logic if_reset_o
);
    AST_ENTRY_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hold_active_o) |-> !$past(sclk_s)); // R4
    AST_EXIT_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hold_active_o) |-> (!$past(sclk_s) || if_reset_o)); // R6
    AST_NO_DRIVE_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_active_o |-> !do_oe_o); // R7
    AST_CLOCK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_active_o |-> (!clk_gate_en_o && !sclk_int_o)); // R8
    AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clk_gate_en_o && $past(!clk_gate_en_o)) |-> $stable(sdi_int_o)); // R8
    AST_RESET_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        if_reset_o |=> !if_reset_o); // R9
    AST_RESET_FROM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        if_reset_o |-> $past(hold_active_o)); // R9
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_s       (sclk_s),
    .hold_active_o(hold_active_o),
    .do_oe_o      (do_oe_o),
    .clk_gate_en_o(clk_gate_en_o),
    .sclk_int_o   (sclk_int_o),
    .sdi_int_o    (sdi_int_o),
    .if_reset_o   (if_reset_o)
);

// File: tb/spi_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_hold_ctrl_tb_top;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, sdi = 1'b0, drive_req = 1'b1;
    logic hold_active, do_oe, gate_en, sclk_int, sdi_int, if_reset;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    spi_hold_ctrl #(.SYNC_STAGES(2)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cs_n_i       (cs_n),
        .sclk_i       (sclk),
        .hold_n_i     (hold_n),
        .sdi_i        (sdi),
        .drive_req_i  (drive_req),
        .hold_active_o(hold_active),
        .do_oe_o      (do_oe),
        .clk_gate_en_o(gate_en),
        .sclk_int_o   (sclk_int),
        .sdi_int_o    (sdi_int),
        .if_reset_o   (if_reset)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_resets(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (if_reset) pulses++;
        end
    endtask

    task automatic t_reset;
        chk("R1 hold_active", hold_active, 1'b0);
        chk("R1 if_reset", if_reset, 1'b0);
        chk("R1 clk_gate_en", gate_en, 1'b1);
        chk("R1 do_oe", do_oe, 1'b0);
        chk("R7 do_oe deselected", do_oe, 1'b0);
    endtask

    task automatic t_entry_clk_low;
        logic frozen;
        cs_n = 1'b0; cyc(LAT);
        chk("R7 do_oe selected", do_oe, 1'b1);
        sclk = 1'b1; cyc(LAT);
        chk("R8 sclk_int follows", sclk_int, 1'b1);
        sclk = 1'b0; cyc(LAT);
        hold_n = 1'b0; cyc(LAT);
        chk("R3 hold entered", hold_active, 1'b1);
        chk("R7 do_oe in hold", do_oe, 1'b0);
        chk("R8 gate off", gate_en, 1'b0);
        frozen = sdi_int;
        sdi = ~sdi; sclk = 1'b1; cyc(LAT);
        chk("R8 sclk_int gated", sclk_int, 1'b0);
        chk("R8 sdi_int frozen", sdi_int, frozen);
        sclk = 1'b0; cyc(LAT);
        hold_n = 1'b1; cyc(LAT);
        chk("R6 exit clk low", hold_active, 1'b0);
        chk("R8 sdi_int live", sdi_int, sdi);
        chk("R7 do_oe resumes", do_oe, 1'b1);
    endtask

    task automatic t_entry_clk_high;
        sclk = 1'b1; cyc(LAT);
        hold_n = 1'b0; cyc(LAT);
        chk("R4 waits high phase", hold_active, 1'b0);
        sclk = 1'b0; cyc(LAT);
        chk("R4 enters on low", hold_active, 1'b1);
        sclk = 1'b1; cyc(LAT);
        hold_n = 1'b1; cyc(LAT);
        chk("R6 exit waits high phase", hold_active, 1'b1);
        sclk = 1'b0; cyc(LAT);
        chk("R6 exit on low", hold_active, 1'b0);
    endtask

    task automatic t_glitch;
        sclk = 1'b1; cyc(LAT);
        hold_n = 1'b0; cyc(3);
        hold_n = 1'b1; cyc(LAT);
        chk("R5 no hold during high", hold_active, 1'b0);
        sclk = 1'b0; cyc(LAT);
        chk("R5 no hold after low", hold_active, 1'b0);
        chk("R5 gate on", gate_en, 1'b1);
    endtask

    task automatic t_deselected;
        cs_n = 1'b1; cyc(LAT);
        hold_n = 1'b0; cyc(LAT);
        chk("R2 no hold deselected", hold_active, 1'b0);
        cs_n = 1'b0; cyc(LAT);
        chk("R2 no hold after select", hold_active, 1'b0);
        chk("R2 gate on", gate_en, 1'b1);
        hold_n = 1'b1; cyc(LAT);
    endtask

    task automatic t_desel_reset;
        int pulses;
        hold_n = 1'b0; cyc(LAT);
        chk("R9 in hold", hold_active, 1'b1);
        cs_n = 1'b1;
        count_resets(10, pulses);
        chk("R9 one reset pulse", pulses == 1, 1'b1);
        chk("R9 hold cleared", hold_active, 1'b0);
        cs_n = 1'b0; cyc(LAT);
        chk("R10 gate stays off", gate_en, 1'b0);
        chk("R10 no drive", do_oe, 1'b0);
        hold_n = 1'b1; cyc(LAT);
        chk("R10 needs fresh select", gate_en, 1'b0);
        cs_n = 1'b1; cyc(LAT);
        cs_n = 1'b0; cyc(LAT);
        chk("R10 gate restored", gate_en, 1'b1);
        chk("R10 drive restored", do_oe, 1'b1);
        hold_n = 1'b0; cyc(LAT);
        chk("R10 hold works again", hold_active, 1'b1);
        hold_n = 1'b1; cyc(LAT);
    endtask

    task automatic t_pending_desel;
        int pulses;
        sclk = 1'b1; cyc(LAT);
        hold_n = 1'b0; cyc(LAT);
        cs_n = 1'b1;
        count_resets(8, pulses);
        chk("R11 no reset pulse", pulses == 0, 1'b1);
        sclk = 1'b0; cyc(LAT);
        chk("R11 no hold", hold_active, 1'b0);
        hold_n = 1'b1; cyc(LAT);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_entry_clk_low();
        t_entry_clk_high();
        t_glitch();
        t_deselected();
        t_desel_reset();
        t_pending_desel();
        finish_run();
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule